// File: doc/BRIEF.md
# Dual-Clock Reversible Counter

This block is a 4-bit counter with two count inputs: a rising edge on the up input adds one and a rising edge on the down input subtracts one. A parameter selects a decade sequence (0 to 9) or a full binary sequence (0 to 15). An active-high clear and an active-low preset load set the count directly. Two active-low terminal-count outputs, carry and borrow, follow the low phase of the matching count input at the top and bottom of the range. Because of this, they can drive the count inputs of the next digit with no extra logic.

The block runs on a fast system clock. The count inputs are slow, asynchronous strobes. Each one passes through a synchronizer followed by an edge-detect register. Clear and load are sampled directly and take effect on the next system clock edge. The edge-detect register keeps following its input while clear or load is active. A count input that is held low through a clear or load and then rises is therefore counted.

Top module: `updown_counter`

## Requirements
- R1: With DECADE=0 the count runs 0..15. Counting up from 15 gives 0 and counting down from 0 gives 15.
- R2: With DECADE=1 the count runs 0..9. Counting up from 9 gives 0 and counting down from 0 gives 9.
- R3: A rising edge on `up_clk_i` adds one to `count_o`, and a rising edge on `dn_clk_i` subtracts one. In both cases the change appears on the third system clock edge after the input rises. With no edge, no clear and no load, the count is held.
- R4: `clear_i` high sets `count_o` to 0 on the next edge. It overrides `load_n_i` and both count inputs. Count edges that occur while clear is high are discarded.
- R5: With `clear_i` low and `load_n_i` low, `preset_i` is copied to `count_o` on the next edge, whatever the count inputs are doing.
- R6: `carry_n_o` is low only while the count is at its top and the synchronized `up_clk_i` level is low. The top is 15 in binary mode. In decade mode the top is decoded from bits 0 and 3 only, so 9, 11, 13 and 15 all qualify.
- R7: `borrow_n_o` is low only while `count_o` is 0 and the synchronized `dn_clk_i` level is low.
- R8: A rising edge on one count input is not counted while the other count input is low.
- R9: A count input that is low during a clear or load and stays low afterwards is counted on its next rising edge.
- R10: In decade mode, counting up from 10..15 gives 0 and counting down from 10..15 gives 9.
- R11: Two counters chained through carry to up and borrow to down count as a two-digit counter.
- R12: While `rst` is high, `count_o` is 0 and both terminal-count outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| up_clk_i | input | 1 | Count-up strobe, rising edge active |
| dn_clk_i | input | 1 | Count-down strobe, rising edge active |
| clear_i | input | 1 | Clear to zero, active high, highest priority |
| load_n_i | input | 1 | Preset load, active low |
| preset_i | input | WIDTH | Value loaded by `load_n_i` |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry, follows the up strobe's low phase at the top |
| borrow_n_o | output | 1 | Active-low borrow, follows the down strobe's low phase at zero |

## Verification
The assertions check on every cycle that:
- clear and load take effect on the next edge with the correct priority;
- the count never moves without a detected edge;
- an edge is discarded while the opposite strobe is low;
- decade recovery from illegal values is correct;
- carry and borrow go low only in the correct count states.

Other behaviours can only be shown by the bench's scenarios against its reference model. These are:
- the three-edge latency from a strobe to the count;
- that an edge is kept when a strobe is held low across a load or a clear;
- the wrap points of both modes;
- that a two-digit chain built from carry and borrow counts correctly.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

endpackage

// File: rtl/updown_strobe_sync.sv
module updown_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic level_o,
  output logic held_o,
  output logic rise_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              held_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= strobe_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[LAST-1:0], strobe_i};
      end
    end
  endgenerate

  // The edge register follows the synchronized level at all times, including
  // during clear/load, so a low level held across them leaves a later rise
  // visible.
  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b1;
    else     held_q <= sync_q[LAST];
  end

  assign level_o = sync_q[LAST];
  assign held_o  = held_q;
  assign rise_o  = sync_q[LAST] & ~held_q;

endmodule

// File: rtl/updown_count_core.sv
module updown_count_core
  import updown_counter_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] TOP_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO    = '0;

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;

  generate
    if (DECADE) begin : g_decade
      always_comb begin
        inc_val = (count_q >= TOP_VAL) ? ZERO : count_q + 1'b1;
        dec_val = ((count_q == ZERO) || (count_q > TOP_VAL)) ? TOP_VAL
                                                             : count_q - 1'b1;
      end
    end else begin : g_binary
      always_comb begin
        inc_val = count_q + 1'b1;
        dec_val = count_q - 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_q <= ZERO;
    end else if (!load_n_i) begin
      count_q <= preset_i;
    end else begin
      unique case (step_i)
        STEP_UP:   count_q <= inc_val;
        STEP_DOWN: count_q <= dec_val;
        default:   count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/updown_tc_decode.sv
module updown_tc_decode #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_held_i,
  input  logic             dn_held_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic at_top;

  generate
    if (DECADE) begin : g_decade
      // Sparse decode: lowest and highest bit only.
      assign at_top = count_i[0] & count_i[WIDTH-1];
    end else begin : g_binary
      assign at_top = &count_i;
    end
  endgenerate

  assign carry_n_o  = ~(at_top & ~up_held_i);
  assign borrow_n_o = ~((count_i == '0) & ~dn_held_i);

endmodule

// File: rtl/updown_counter.sv
module updown_counter
  import updown_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_clk_i,
  input  logic             dn_clk_i,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic  up_lvl, up_held, up_rise;
  logic  dn_lvl, dn_held, dn_rise;
  logic  up_ev, dn_ev;
  step_e step;

  updown_strobe_sync #(.STAGES(SYNC_STAGES)) up_sync_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (up_clk_i),
    .level_o  (up_lvl),
    .held_o   (up_held),
    .rise_o   (up_rise)
  );

  updown_strobe_sync #(.STAGES(SYNC_STAGES)) dn_sync_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (dn_clk_i),
    .level_o  (dn_lvl),
    .held_o   (dn_held),
    .rise_o   (dn_rise)
  );

  // An edge counts only while the opposite strobe sits high.
  assign up_ev = up_rise & dn_lvl;
  assign dn_ev = dn_rise & up_lvl;

  always_comb begin
    if (up_ev && !dn_ev)      step = STEP_UP;
    else if (dn_ev && !up_ev) step = STEP_DOWN;
    else                      step = STEP_HOLD;
  end

  updown_count_core #(.WIDTH(WIDTH), .DECADE(DECADE)) core_i (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear_i),
    .load_n_i (load_n_i),
    .preset_i (preset_i),
    .step_i   (step),
    .count_o  (count_o)
  );

  updown_tc_decode #(.WIDTH(WIDTH), .DECADE(DECADE)) tc_i (
    .count_i    (count_o),
    .up_held_i  (up_held),
    .dn_held_i  (dn_held),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

endmodule

// File: rtl/updown_counter_chk.sv
module updown_counter_chk #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o,
  input logic             up_ev,
  input logic             dn_ev,
  input logic             up_rise,
  input logic             dn_rise,
  input logic             dn_lvl
);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (count_o == '0));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !load_n_i) |=> (count_o == $past(preset_i)));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && !up_ev && !dn_ev) |=> $stable(count_o));

  // R8
  other_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && up_rise && !dn_lvl && !dn_rise) |=> $stable(count_o));

  // R10
  decade_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (DECADE && !clear_i && load_n_i && up_ev && !dn_ev && (count_o >= WIDTH'(9)))
      |=> (count_o == '0));

  // R6
  carry_state_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |-> (DECADE ? (count_o[0] && count_o[WIDTH-1]) : (&count_o)));

  // R7
  borrow_state_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n_o |-> (count_o == '0));

endmodule

bind updown_counter updown_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clear_i    (clear_i),
  .load_n_i   (load_n_i),
  .preset_i   (preset_i),
  .count_o    (count_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o),
  .up_ev      (up_ev),
  .dn_ev      (dn_ev),
  .up_rise    (up_rise),
  .dn_rise    (dn_rise),
  .dn_lvl     (dn_lvl)
);

// File: tb/updown_counter_tb_top.sv
module updown_counter_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic       up_c, dn_c, clr, ld_n;
  logic [3:0] pre;
  logic [3:0] dec_q, bin_q;
  logic       dec_cy, dec_bw, bin_cy, bin_bw;

  logic       c_up, c_dn, c_clr;
  logic [3:0] lo_q, hi_q;
  logic       lo_cy, lo_bw, hi_cy, hi_bw;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R3";
  bit    done    = 1'b0;

  updown_counter #(.DECADE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .up_clk_i(up_c), .dn_clk_i(dn_c), .clear_i(clr),
    .load_n_i(ld_n), .preset_i(pre), .count_o(dec_q),
    .carry_n_o(dec_cy), .borrow_n_o(dec_bw));

  updown_counter #(.DECADE(1'b0)) bin_i (
    .clk(clk), .rst(rst), .up_clk_i(up_c), .dn_clk_i(dn_c), .clear_i(clr),
    .load_n_i(ld_n), .preset_i(pre), .count_o(bin_q),
    .carry_n_o(bin_cy), .borrow_n_o(bin_bw));

  // R11 two-digit decade chain
  updown_counter #(.DECADE(1'b1)) lo_i (
    .clk(clk), .rst(rst), .up_clk_i(c_up), .dn_clk_i(c_dn), .clear_i(c_clr),
    .load_n_i(1'b1), .preset_i(4'd0), .count_o(lo_q),
    .carry_n_o(lo_cy), .borrow_n_o(lo_bw));

  updown_counter #(.DECADE(1'b1)) hi_i (
    .clk(clk), .rst(rst), .up_clk_i(lo_cy), .dn_clk_i(lo_bw), .clear_i(c_clr),
    .load_n_i(1'b1), .preset_i(4'd0), .count_o(hi_q),
    .carry_n_o(hi_cy), .borrow_n_o(hi_bw));

  // Behavioural reference: strobe history kept in queues, counts as integers.
  int mq_dec, mq_bin;
  bit uq[$];
  bit dq[$];

  always @(posedge clk) begin
    if (rst) begin
      mq_dec = 0;
      mq_bin = 0;
      uq = {1'b1, 1'b1, 1'b1};
      dq = {1'b1, 1'b1, 1'b1};
    end else begin
      bit ue, de;
      ue = uq[1] && !uq[2] && dq[1];
      de = dq[1] && !dq[2] && uq[1];
      if (clr) begin
        mq_dec = 0;
        mq_bin = 0;
      end else if (!ld_n) begin
        mq_dec = int'(pre);
        mq_bin = int'(pre);
      end else if (ue && !de) begin
        mq_dec = (mq_dec >= 9) ? 0 : mq_dec + 1;
        mq_bin = (mq_bin + 1) % 16;
      end else if (de && !ue) begin
        mq_dec = (mq_dec == 0 || mq_dec > 9) ? 9 : mq_dec - 1;
        mq_bin = (mq_bin + 15) % 16;
      end
      uq.push_front(up_c); void'(uq.pop_back());
      dq.push_front(dn_c); void'(dq.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit e_dcy, e_bcy, e_dbw, e_bbw;
      e_dcy = !(((mq_dec % 2) == 1) && (mq_dec >= 8) && !uq[2]);
      e_bcy = !((mq_bin == 15) && !uq[2]);
      e_dbw = !((mq_dec == 0) && !dq[2]);
      e_bbw = !((mq_bin == 0) && !dq[2]);
      chk({cur_req, " decade count"}, int'(dec_q), mq_dec);
      chk({cur_req, " binary count"}, int'(bin_q), mq_bin);
      chk("R6 decade carry", int'(dec_cy), int'(e_dcy));
      chk("R6 binary carry", int'(bin_cy), int'(e_bcy));
      chk("R7 decade borrow", int'(dec_bw), int'(e_dbw));
      chk("R7 binary borrow", int'(bin_bw), int'(e_bbw));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up(int n);
    for (int i = 0; i < n; i++) begin
      up_c = 1'b0; wait_n(5);
      up_c = 1'b1; wait_n(5);
    end
  endtask

  task automatic pulse_dn(int n);
    for (int i = 0; i < n; i++) begin
      dn_c = 1'b0; wait_n(5);
      dn_c = 1'b1; wait_n(5);
    end
  endtask

  task automatic do_load(int v);
    pre = 4'(v);
    ld_n = 1'b0; wait_n(2);
    ld_n = 1'b1; wait_n(2);
    chk("R5 load decade", int'(dec_q), v);
    chk("R5 load binary", int'(bin_q), v);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; up_c = 1'b1; dn_c = 1'b1; clr = 1'b0; ld_n = 1'b1; pre = 4'd0;
    c_up = 1'b1; c_dn = 1'b1; c_clr = 1'b0;
    wait_n(3);
    // R12 state while reset is held
    chk("R12 count", int'(dec_q), 0);
    chk("R12 carry", int'(dec_cy), 1);
    chk("R12 borrow", int'(bin_bw), 1);
    rst = 1'b0;
    wait_n(1);

    // R3 / R2 / R1: twelve up edges
    cur_req = "R3";
    pulse_up(12);
    chk("R2 decade wrap up", int'(dec_q), 2);
    chk("R1 binary up", int'(bin_q), 12);

    // R6 carry at 9 in decade mode
    cur_req = "R2";
    do_load(9);
    up_c = 1'b0; wait_n(5);
    chk("R6 carry low at 9", int'(dec_cy), 0);
    chk("R6 binary carry high at 9", int'(bin_cy), 1);
    up_c = 1'b1; wait_n(5);
    chk("R2 9 to 0", int'(dec_q), 0);
    chk("R6 carry released", int'(dec_cy), 1);

    // R6 / R10 / R1 at 15
    cur_req = "R10";
    do_load(15);
    up_c = 1'b0; wait_n(5);
    chk("R6 binary carry at 15", int'(bin_cy), 0);
    chk("R6 decade sparse carry at 15", int'(dec_cy), 0);
    up_c = 1'b1; wait_n(5);
    chk("R10 up from 15", int'(dec_q), 0);
    chk("R1 binary 15 to 0", int'(bin_q), 0);

    // R7 borrow and down wrap
    cur_req = "R1";
    do_load(0);
    dn_c = 1'b0; wait_n(5);
    chk("R7 borrow low", int'(dec_bw), 0);
    dn_c = 1'b1; wait_n(5);
    chk("R2 0 to 9", int'(dec_q), 9);
    chk("R1 0 to 15", int'(bin_q), 15);
    chk("R7 borrow released", int'(dec_bw), 1);

    // R10 down from an illegal decade value
    cur_req = "R10";
    do_load(12);
    pulse_dn(1);
    chk("R10 down from 12", int'(dec_q), 9);
    chk("R3 binary down", int'(bin_q), 11);

    // R8 other strobe low blocks counting
    cur_req = "R8";
    do_load(4);
    up_c = 1'b0; wait_n(5);
    pulse_dn(1);
    chk("R8 decade blocked", int'(dec_q), 4);
    chk("R8 binary blocked", int'(bin_q), 4);
    up_c = 1'b1; wait_n(5);
    chk("R8 later up counted", int'(dec_q), 5);

    // R9 strobe held low across a load
    cur_req = "R9";
    up_c = 1'b0; wait_n(5);
    do_load(3);
    up_c = 1'b1; wait_n(5);
    chk("R9 after load", int'(dec_q), 4);
    chk("R9 after load binary", int'(bin_q), 4);

    // R9 strobe held low across a clear
    dn_c = 1'b0; wait_n(5);
    clr = 1'b1; wait_n(2);
    clr = 1'b0; wait_n(2);
    chk("R4 clear", int'(dec_q), 0);
    dn_c = 1'b1; wait_n(5);
    chk("R9 after clear", int'(dec_q), 9);
    chk("R9 after clear binary", int'(bin_q), 15);

    // R4 clear beats load and count edges
    cur_req = "R4";
    pre = 4'd6; clr = 1'b1; ld_n = 1'b0; up_c = 1'b0; wait_n(3);
    chk("R4 priority decade", int'(dec_q), 0);
    chk("R4 priority binary", int'(bin_q), 0);
    up_c = 1'b1; wait_n(5);
    clr = 1'b0; ld_n = 1'b1; wait_n(3);
    chk("R4 edge during clear discarded", int'(dec_q), 0);

    // R11 two-digit chain
    cur_req = "R11";
    for (int i = 0; i < 25; i++) begin
      c_up = 1'b0; wait_n(5);
      c_up = 1'b1; wait_n(5);
    end
    wait_n(10);
    chk("R11 low digit up", int'(lo_q), 5);
    chk("R11 high digit up", int'(hi_q), 2);
    for (int i = 0; i < 7; i++) begin
      c_dn = 1'b0; wait_n(5);
      c_dn = 1'b1; wait_n(5);
    end
    wait_n(10);
    chk("R11 low digit down", int'(lo_q), 8);
    chk("R11 high digit down", int'(hi_q), 1);

    finish_run();
  end

endmodule